// File: doc/BRIEF.md
# Compare-Conditioned Event Latch Bank

This block holds a bank of event latch groups. Each group pairs a latch register with a mask register, and one compare register is shared by all groups. External single-cycle pulses set latch bits. Software clears or sets latch bits with a conditional write. A written bit is accepted only where the compare register holds the value that software believes the bit has now. Software therefore loads the compare register with the value it last read, then writes the new value. Any bit that hardware raised after that read keeps its set state, so no event is lost to a read-modify-write race.

Each group reduces to one summary bit: the OR of latch AND mask. The summary bits form a read-only register. An interrupt mask register gates the summary bits, and the gated result drives a single registered interrupt line. One group can be built as the exception-status variant, which has a fixed set of implemented bits.

The local register offsets are the following. Latch g sits at 2g and its mask at 2g+1. Compare sits at 2·N_GRP, the summary at 2·N_GRP+1 and the interrupt mask at 2·N_GRP+2. Any higher offset is unused.

Top module: `evl_bank`

## Requirements
- R1: After reset all latches, masks, the compare register and the interrupt mask read zero, and irq_o is low.
- R2: A pulse on evt_i bit g·W+b at a clock edge makes latch g bit b read one after that edge.
- R3: A write to latch g changes bit b to wdata_i[b] only if compare bit b equals the current latch bit. Bits whose compare bit differs keep their value.
- R4: When an event pulse and a conditional write hit the same latch bit in the same cycle, the bit ends up set.
- R5: Writes to a mask register, the compare register or the interrupt mask take effect at the clock edge without condition and read back unchanged (apart from the bits that R9 fixes).
- R6: Latch g reads at offset 2g and mask g at 2g+1, compare at 2·N_GRP, summary at 2·N_GRP+1 and interrupt mask at 2·N_GRP+2. Other offsets read zero, and writes to them change nothing.
- R7: Summary bit g equals the OR over the bits of (latch g AND mask g). The summary register ignores writes.
- R8: irq_o equals the OR over (summary AND interrupt mask) as it stood one cycle earlier.
- R9: In the exception group (default group N_GRP-1), latch bits 7, 6, 5 and 0 are implemented, and bits 4:1 always read zero, whatever events or writes arrive. In its mask, bits 6, 5 and 0 are implemented, and bits 7 and 4:1 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_GRP*W | Event pulses, W bits per group, group 0 in the low bits |
| wr_en_i | input | 1 | Write strobe for the register at addr_i |
| addr_i | input | AW | Local register offset for both read and write |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data for addr_i, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that evt_i carries pulses the design may see in any cycle, even together with a write to the same latch. They also assume that addr_i and wdata_i settle between edges. No handshake is assumed. The stimulus drives every input a short time after a rising edge and holds it through the next edge, so each write and each event lands in exactly one cycle. The stimulus covers pulses that coincide with conditional writes, compare patterns that match some bits and not others, and writes to the read-only summary and to unused offsets. It observes the results only by reading the registers back and by watching irq_o.

// File: rtl/evl_pkg.sv
package evl_pkg;

   // implemented bits of the exception-status latch: 7 write-inhibit,
   // 6 command error, 5 control parity error, 0 internal parity error
   localparam logic [7:0] EXC_LATCH_BITS = 8'hE1;
   // exception mask: bit 7 is never implemented
   localparam logic [7:0] EXC_MASK_BITS  = 8'h61;

   function automatic int unsigned latch_off(input int unsigned g);
      return 2 * g;
   endfunction

   function automatic int unsigned mask_off(input int unsigned g);
      return 2 * g + 1;
   endfunction

   function automatic int unsigned cmp_off(input int unsigned n);
      return 2 * n;
   endfunction

   function automatic int unsigned sum_off(input int unsigned n);
      return 2 * n + 1;
   endfunction

   function automatic int unsigned imask_off(input int unsigned n);
      return 2 * n + 2;
   endfunction

endpackage

// File: rtl/evl_cond_latch.sv
module evl_cond_latch #(
   parameter int         W       = 8,
   parameter logic [W-1:0] IMPL  = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] cmp_i,
   output logic [W-1:0] q_o
);

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (IMPL[b]) begin : g_impl
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else if (set_i[b])
               bit_q <= 1'b1;
            else if (wr_i && (cmp_i[b] == bit_q))
               bit_q <= wdata_i[b];
         end
         assign q_o[b] = bit_q;
      end else begin : g_rsvd
         assign q_o[b] = 1'b0;
      end
   end

   // R2
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i & IMPL) != '0 |=> ((q_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i && set_i == '0) |=> $stable(q_o));

   // R3
   mismatch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> ((q_o ^ $past(q_o)) & $past(cmp_i ^ q_o) & ~$past(set_i)) == '0);

endmodule

// File: rtl/evl_mask_reg.sv
module evl_mask_reg #(
   parameter int           W    = 8,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] store_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         store_q <= '0;
      else if (wr_i)
         store_q <= wdata_i & IMPL;
   end

   assign q_o = store_q;

   // R5
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> q_o == ($past(wdata_i) & IMPL));

endmodule

// File: rtl/evl_irq_sum.sv
module evl_irq_sum #(
   parameter int N_GRP = 4,
   parameter int W     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_GRP*W-1:0] latch_i,
   input  logic [N_GRP*W-1:0] mask_i,
   input  logic [N_GRP-1:0]   imask_i,
   output logic [N_GRP-1:0]   summary_o,
   output logic               irq_o
);

   for (genvar g = 0; g < N_GRP; g++) begin : g_sum
      assign summary_o[g] = |(latch_i[g*W +: W] & mask_i[g*W +: W]);
   end

   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else
         irq_q <= |(summary_o & imask_i);
   end

   assign irq_o = irq_q;

   // R8
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (summary_o & imask_i) != '0 |=> irq_o);

   // R8
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (summary_o & imask_i) == '0 |=> !irq_o);

endmodule

// File: rtl/evl_bank.sv
module evl_bank
   import evl_pkg::*;
#(
   parameter int  N_GRP   = 4,
   parameter int  W       = 8,
   parameter bit  EXC_EN  = 1'b1,
   parameter int  EXC_GRP = N_GRP - 1,
   localparam int AW      = $clog2(2 * N_GRP + 3)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_GRP*W-1:0] evt_i,
   input  logic               wr_en_i,
   input  logic [AW-1:0]      addr_i,
   input  logic [W-1:0]       wdata_i,
   output logic [W-1:0]       rdata_o,
   output logic               irq_o
);

   localparam logic [W-1:0] EXC_LAT_V = W'(EXC_LATCH_BITS);
   localparam logic [W-1:0] EXC_MSK_V = W'(EXC_MASK_BITS);
   localparam logic [AW-1:0] CMP_A  = AW'(cmp_off(N_GRP));
   localparam logic [AW-1:0] SUM_A  = AW'(sum_off(N_GRP));
   localparam logic [AW-1:0] IMSK_A = AW'(imask_off(N_GRP));

   // elaboration checks
   if (N_GRP < 1) begin : g_err_n
      $error("evl_bank: N_GRP must be at least 1");
   end
   if (N_GRP > W) begin : g_err_sum
      $error("evl_bank: summary must fit in one data word (N_GRP <= W)");
   end
   if (EXC_EN && (W < 8)) begin : g_err_w
      $error("evl_bank: exception group needs W >= 8");
   end
   if (EXC_EN && (EXC_GRP < 0 || EXC_GRP >= N_GRP)) begin : g_err_exc
      $error("evl_bank: EXC_GRP out of range");
   end

   // write decode
   logic [N_GRP-1:0] lat_we, msk_we;
   logic             cmp_we, imsk_we;

   always_comb begin
      for (int g = 0; g < N_GRP; g++) begin
         lat_we[g] = wr_en_i && (addr_i == AW'(latch_off(g)));
         msk_we[g] = wr_en_i && (addr_i == AW'(mask_off(g)));
      end
      cmp_we  = wr_en_i && (addr_i == CMP_A);
      imsk_we = wr_en_i && (addr_i == IMSK_A);
   end

   // shared registers
   logic [W-1:0]     cmp_q;
   logic [N_GRP-1:0] imsk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         imsk_q <= '0;
      end else begin
         if (cmp_we)
            cmp_q <= wdata_i;
         if (imsk_we)
            imsk_q <= wdata_i[N_GRP-1:0];
      end
   end

   // R5
   cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_we |=> cmp_q == $past(wdata_i));

   // groups
   logic [N_GRP*W-1:0] lat_flat, msk_flat;

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      if (EXC_EN && g == EXC_GRP) begin : g_exc
         evl_cond_latch #(.W(W), .IMPL(EXC_LAT_V)) u_lat (
            .clk(clk), .rst_n(rst_n), .set_i(evt_i[g*W +: W]),
            .wr_i(lat_we[g]), .wdata_i(wdata_i), .cmp_i(cmp_q),
            .q_o(lat_flat[g*W +: W]));
         evl_mask_reg #(.W(W), .IMPL(EXC_MSK_V)) u_msk (
            .clk(clk), .rst_n(rst_n), .wr_i(msk_we[g]),
            .wdata_i(wdata_i), .q_o(msk_flat[g*W +: W]));
      end else begin : g_std
         evl_cond_latch #(.W(W), .IMPL({W{1'b1}})) u_lat (
            .clk(clk), .rst_n(rst_n), .set_i(evt_i[g*W +: W]),
            .wr_i(lat_we[g]), .wdata_i(wdata_i), .cmp_i(cmp_q),
            .q_o(lat_flat[g*W +: W]));
         evl_mask_reg #(.W(W), .IMPL({W{1'b1}})) u_msk (
            .clk(clk), .rst_n(rst_n), .wr_i(msk_we[g]),
            .wdata_i(wdata_i), .q_o(msk_flat[g*W +: W]));
      end
   end

   // summary and interrupt
   logic [N_GRP-1:0] summary;

   evl_irq_sum #(.N_GRP(N_GRP), .W(W)) u_sum (
      .clk(clk), .rst_n(rst_n), .latch_i(lat_flat), .mask_i(msk_flat),
      .imask_i(imsk_q), .summary_o(summary), .irq_o(irq_o));

   // read mux
   always_comb begin
      rdata_o = '0;
      for (int g = 0; g < N_GRP; g++) begin
         if (addr_i == AW'(latch_off(g)))
            rdata_o = lat_flat[g*W +: W];
         if (addr_i == AW'(mask_off(g)))
            rdata_o = msk_flat[g*W +: W];
      end
      if (addr_i == CMP_A)
         rdata_o = cmp_q;
      if (addr_i == SUM_A)
         rdata_o = W'(summary);
      if (addr_i == IMSK_A)
         rdata_o = W'(imsk_q);
   end

endmodule

// File: tb/evl_bank_test.sv
module evl_bank_test;

   localparam int N   = 4;
   localparam int W   = 8;
   localparam int EXC = N - 1;
   localparam int AW  = $clog2(2 * N + 3);
   localparam int CMP = 2 * N;
   localparam int SUM = 2 * N + 1;
   localparam int IMK = 2 * N + 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N*W-1:0] evt = '0;
   logic           wr_en = 1'b0;
   logic [AW-1:0]  addr = '0;
   logic [W-1:0]   wdata = '0;
   logic [W-1:0]   rdata;
   logic           irq;

   always #10 clk = ~clk;

   evl_bank #(.N_GRP(N), .W(W)) uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // reference model, built from the requirements
   logic [W-1:0] m_lat [N];
   logic [W-1:0] m_msk [N];
   logic [W-1:0] m_cmp;
   logic [N-1:0] m_imk;
   logic         m_irq;

   function automatic logic [W-1:0] lat_impl(input int g);
      return (g == EXC) ? 8'hE1 : 8'hFF;   // R9
   endfunction

   function automatic logic [W-1:0] msk_impl(input int g);
      return (g == EXC) ? 8'h61 : 8'hFF;   // R9
   endfunction

   function automatic logic [N-1:0] m_summary();
      logic [N-1:0] s;
      for (int g = 0; g < N; g++) s[g] = |(m_lat[g] & m_msk[g]);
      return s;
   endfunction

   function automatic logic [W-1:0] m_read(input int a);
      if (a < 2 * N) return (a % 2 == 0) ? m_lat[a/2] : m_msk[a/2];
      if (a == CMP) return m_cmp;
      if (a == SUM) return W'(m_summary());
      if (a == IMK) return W'(m_imk);
      return '0;
   endfunction

   typedef struct {
      logic [W-1:0] d;
      logic         irq;
      string        tag;
   } item_t;

   item_t sb[$];
   bit    mon_req = 0;

   // monitor: pops one expected item per requested read
   always @(negedge clk) begin
      if (mon_req && sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (rdata !== it.d) begin
            failures++;
            $display("FAIL %s: rdata actual=%h expected=%h", it.tag, rdata, it.d);
         end
         checks++;
         if (irq !== it.irq) begin
            failures++;
            $display("FAIL %s (R8 irq): actual=%b expected=%b", it.tag, irq, it.irq);
         end
      end
   end

   task automatic step(input logic we, input int a, input logic [W-1:0] d,
                       input logic [N*W-1:0] ev);
      logic [W-1:0] nl [N];
      logic [W-1:0] nm [N];
      logic         nirq;
      wr_en = we;
      if (we) addr = AW'(a);
      wdata = d;
      evt = ev;
      @(posedge clk);
      nirq = |(m_summary() & m_imk);
      for (int g = 0; g < N; g++) begin
         logic [W-1:0] es, wm;
         es = ev[g*W +: W] & lat_impl(g);
         wm = (we && a == 2 * g) ? ~(m_cmp ^ m_lat[g]) : '0;
         nl[g] = (es | (~es & ((wm & d) | (~wm & m_lat[g])))) & lat_impl(g);
         nm[g] = (we && a == 2 * g + 1) ? (d & msk_impl(g)) : m_msk[g];
      end
      if (we && a == CMP) m_cmp = d;
      if (we && a == IMK) m_imk = d[N-1:0];
      for (int g = 0; g < N; g++) begin
         m_lat[g] = nl[g];
         m_msk[g] = nm[g];
      end
      m_irq = nirq;
      #2;
      wr_en = 1'b0;
      evt = '0;
   endtask

   task automatic rd(input int a, input string tag);
      item_t it;
      addr = AW'(a);
      it.d = m_read(a);
      it.irq = m_irq;
      it.tag = tag;
      sb.push_back(it);
      mon_req = 1;
      step(1'b0, a, '0, '0);
      mon_req = 0;
   endtask

   function automatic logic [N*W-1:0] ev_on(input int g, input logic [W-1:0] v);
      logic [N*W-1:0] e;
      e = '0;
      e[g*W +: W] = v;
      return e;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      for (int g = 0; g < N; g++) begin
         m_lat[g] = '0;
         m_msk[g] = '0;
      end
      m_cmp = '0;
      m_imk = '0;
      m_irq = 1'b0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 / R6: every offset after reset
      for (int a = 0; a < (1 << AW); a++) rd(a, "R1 reset value");

      // R2: event pulse sets a latch bit
      step(1'b0, 0, '0, ev_on(0, 8'h08));
      rd(0, "R2 event set");

      // R3: compare mismatch keeps the bit
      step(1'b1, 0, 8'h00, '0);
      rd(0, "R3 mismatch kept");

      // R5: compare readback; R3 matched clear
      step(1'b1, CMP, 8'h08, '0);
      rd(CMP, "R5 compare readback");
      step(1'b1, 0, 8'h00, '0);
      rd(0, "R3 matched clear");

      // R3: mixed match and mismatch
      step(1'b0, 0, '0, ev_on(2, 8'hF0));
      step(1'b1, CMP, 8'h30, '0);
      step(1'b1, 4, 8'h0F, '0);
      rd(4, "R3 partial write");

      // R4: event coincides with conditional clear
      step(1'b0, 0, '0, ev_on(1, 8'h81));
      step(1'b1, CMP, 8'h81, '0);
      step(1'b1, 2, 8'h00, ev_on(1, 8'h01));
      rd(2, "R4 event beats write");

      // R5 mask, R7 summary
      step(1'b1, 3, 8'h01, '0);
      rd(3, "R5 mask readback");
      rd(SUM, "R7 summary value");
      step(1'b1, SUM, 8'hFF, '0);
      rd(SUM, "R7 summary write ignored");

      // R8: interrupt path, one cycle behind
      step(1'b1, IMK, 8'h02, '0);
      rd(IMK, "R5 imask readback");
      rd(IMK, "R8 irq asserted");
      step(1'b1, CMP, 8'h01, '0);
      step(1'b1, 2, 8'h00, '0);
      rd(2, "R8 irq lags clear");
      rd(2, "R8 irq dropped");

      // R6: unused offset
      step(1'b1, IMK + 1, 8'hFF, '0);
      rd(IMK + 1, "R6 unused offset");
      rd(CMP, "R6 compare untouched");
      rd(IMK, "R6 imask untouched");

      // R9: exception group
      step(1'b0, 0, '0, ev_on(EXC, 8'hFF));
      rd(2 * EXC, "R9 exception latch bits");
      step(1'b1, 2 * EXC + 1, 8'hFF, '0);
      rd(2 * EXC + 1, "R9 exception mask bits");
      step(1'b1, CMP, 8'hFF, '0);
      step(1'b1, 2 * EXC, 8'h00, '0);
      rd(2 * EXC, "R9 exception clear");

      // R3 / R4 / R8 sweep over all groups
      step(1'b1, IMK, 8'h0F, '0);
      for (int i = 0; i < 16; i++) begin
         int g;
         g = i % N;
         step(1'b1, 2 * g + 1, W'(i * 29 + 3), '0);
         step(1'b0, 0, '0, ev_on(g, W'(i * 53 + 17)));
         step(1'b1, CMP, W'(i * 71 + 5), '0);
         step(1'b1, 2 * g, W'(i * 37 + 11), ev_on(g, W'(i * 13 + 1)));
         rd(2 * g, "R3 sweep latch");
         rd(SUM, "R7 sweep summary");
      end

      finish_run();
   end

endmodule